// File: doc/BRIEF.md
# Burst Column-Order Sequencer

This block sits in a memory command path between the command decoder and the column datapath of a DDR3-style SDRAM model or controller. It keeps a copy of mode register 0, which a mode-register-set command loads. From that copy it holds four settings: the burst-length policy, the burst type, the CAS latency and the write recovery. It reports the latency and the recovery as plain cycle counts. A malformed register write is refused as a whole and raises an error flag.

Each accepted read or write column command starts a burst. The block first chooses the burst length, either fixed by the mode register or picked per command from an address bit. It then emits one column address per clock for four or eight beats. The beats follow sequential-wrap or XOR-interleave order, based on the low bits of the starting column. The upper column bits stay fixed for the whole burst. Column commands that arrive while a burst is running are dropped.

Top module: `burst_colseq`

## Requirements
- R1: A mode-register write is taken only when `cmd_vld` is high, `sel_n`, `row_strobe_n`, `col_strobe_n` and `wr_en_n` are all low, and `bank_sel` is 000. The same strobes with another bank value, or any other strobe pattern, leave every setting and `cfg_err` unchanged.
- R2: `cmd_addr[1:0]` sets the burst-length policy. 00 gives an 8-beat burst, 10 gives a 4-beat burst, 01 picks the length per command, and 11 is reserved.
- R3: Under the per-command policy, `cmd_addr[12]` is sampled with the read or write command. 0 gives 4 beats and 1 gives 8 beats. `burst_len` shows the length of the current or most recent burst.
- R4: `cmd_addr[3]`=0 selects sequential order. For 8 beats the low three column bits step up by one per beat, modulo 8. For 4 beats the low two bits step up by one per beat, modulo 4, and bit 2 is held.
- R5: `cmd_addr[3]`=1 selects interleaved order. The low column bits of beat i are the starting low bits XOR i.
- R6: The column comes from `cmd_addr[9:0]`, and bits 9..3 of `beat_col` equal the starting column's bits on every beat.
- R7: A write command has its starting column bits 1:0 forced to 00 before ordering. A read keeps them.
- R8: Write-recovery code `cmd_addr[11:9]` maps 1..4 to 5..8 cycles and 5, 6, 7 to 10, 12, 14 cycles. Code 0 is reserved. `wr_rec` gives the cycle count.
- R9: The CAS latency code is {`cmd_addr[6:4]`, `cmd_addr[2]`}. Even codes 2..14 map to 5..11 cycles. Codes 1, 3 and 5 map to 12, 13 and 14 cycles. Every other code is reserved. `cas_lat` gives the cycle count.
- R10: A mode-register write with a reserved length, latency or recovery code, or with any of `cmd_addr[15:13]` set, changes no setting and sets `cfg_err` one cycle later. A valid write clears `cfg_err`.
- R11: An accepted column command raises `beat_vld` on the next cycle for exactly 4 or 8 consecutive cycles. `beat_last` is high only on the final beat.
- R12: A column command seen while `beat_vld` is high is ignored. The running burst finishes unchanged, and no new burst follows it.
- R13: After reset, `beat_vld`=0, `beat_last`=0, `burst_len`=8, `cas_lat`=5, `wr_rec`=5, `cfg_err`=0, with fixed 8-beat length and sequential order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_vld | input | 1 | Command strobes are valid this cycle |
| sel_n | input | 1 | Chip select, active low |
| row_strobe_n | input | 1 | Row strobe, active low |
| col_strobe_n | input | 1 | Column strobe, active low |
| wr_en_n | input | 1 | Write enable, active low |
| bank_sel | input | 3 | Bank / mode-register select |
| cmd_addr | input | 16 | Address bus |
| beat_col | output | 10 | Column address of the current beat |
| beat_vld | output | 1 | Beat is valid |
| beat_last | output | 1 | Final beat of the burst |
| burst_len | output | 4 | Effective burst length (4 or 8) |
| cas_lat | output | 4 | Decoded CAS latency in cycles |
| wr_rec | output | 4 | Decoded write recovery in cycles |
| cfg_err | output | 1 | Last mode-register write was refused |

## Verification
The bench sweeps every starting column low-bit value against both orders, all four length choices, and both reads and writes. A wrong wrap width would make 4-beat bursts leak into bit 2. A missing write alignment would start writes mid-nibble. It also walks every latency and recovery code. A decoder that accepted a reserved code would corrupt the stored latency, and one that was off by one at the boundary between the two latency code groups would report 11/12 wrongly. It also fires a command in the middle of a burst. A block that re-armed there would restart the column sequence or stretch `beat_vld` beyond its length.

// File: rtl/burst_colseq_pkg.sv
package burst_colseq_pkg;

  localparam int LAT_W = 4;

  typedef enum logic [1:0] {
    BLM_FIX8 = 2'b00,
    BLM_OTF  = 2'b01,
    BLM_FIX4 = 2'b10,
    BLM_RSVD = 2'b11
  } blmode_e;

  typedef struct packed {
    logic [2:0] hi_zero;
    logic [2:0] wr_code;
    logic [3:0] cl_code;
    logic       ilv;
    logic [1:0] bl;
  } mr_fields_t;

  // latency code = {A6,A5,A4,A2}
  function automatic logic cl_ok(input logic [3:0] code);
    if (!code[0]) return (code[3:1] != 3'd0);
    return (code[3:1] <= 3'd2);
  endfunction

  function automatic logic [LAT_W-1:0] cl_cycles(input logic [3:0] code);
    if (!code[0]) return LAT_W'(4) + LAT_W'(code[3:1]);
    return LAT_W'(12) + LAT_W'(code[3:1]);
  endfunction

  function automatic logic wr_ok(input logic [2:0] code);
    return (code != 3'd0);
  endfunction

  function automatic logic [LAT_W-1:0] wr_cycles(input logic [2:0] code);
    if (code <= 3'd4) return LAT_W'(4) + LAT_W'(code);
    return LAT_W'({code, 1'b0});
  endfunction

  function automatic logic len8_of(input blmode_e m, input logic otf_bit);
    return (m == BLM_FIX8) || ((m == BLM_OTF) && otf_bit);
  endfunction

endpackage

// File: rtl/colseq_cmd_dec.sv
module colseq_cmd_dec #(
  parameter int BANK_W = 3
) (
  input  logic              cmd_vld,
  input  logic              sel_n,
  input  logic              row_strobe_n,
  input  logic              col_strobe_n,
  input  logic              wr_en_n,
  input  logic [BANK_W-1:0] bank_sel,
  output logic              mrs0_hit,
  output logic              rd_hit,
  output logic              wr_hit
);

  logic live;
  logic col_cmd;

  assign live     = cmd_vld & ~sel_n;
  assign mrs0_hit = live & ~row_strobe_n & ~col_strobe_n & ~wr_en_n & (bank_sel == '0);
  assign col_cmd  = live & row_strobe_n & ~col_strobe_n;
  assign rd_hit   = col_cmd & wr_en_n;
  assign wr_hit   = col_cmd & ~wr_en_n;

endmodule

// File: rtl/colseq_modereg.sv
module colseq_modereg
  import burst_colseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrs0_hit,
  input  mr_fields_t       fld,
  output blmode_e          blmode,
  output logic             ilv,
  output logic [LAT_W-1:0] cas_lat,
  output logic [LAT_W-1:0] wr_rec,
  output logic             cfg_err,
  output logic             mrs_reject
);

  logic mrs_ok;
  logic mrs_take;

  assign mrs_ok     = (fld.bl != BLM_RSVD) && cl_ok(fld.cl_code) &&
                      wr_ok(fld.wr_code) && (fld.hi_zero == 3'b000);
  assign mrs_take   = mrs0_hit & mrs_ok;
  assign mrs_reject = mrs0_hit & ~mrs_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blmode  <= BLM_FIX8;
      ilv     <= 1'b0;
      cas_lat <= LAT_W'(5);
      wr_rec  <= LAT_W'(5);
      cfg_err <= 1'b0;
    end else begin
      if (mrs_take) begin
        blmode  <= blmode_e'(fld.bl);
        ilv     <= fld.ilv;
        cas_lat <= cl_cycles(fld.cl_code);
        wr_rec  <= wr_cycles(fld.wr_code);
        cfg_err <= 1'b0;
      end else if (mrs_reject) begin
        cfg_err <= 1'b1;
      end
    end
  end

  AST_BAD_MRS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_reject |=> ($stable(cas_lat) && $stable(wr_rec) && $stable(blmode) && $stable(ilv))); // R10
  AST_BAD_MRS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_reject |=> cfg_err); // R10
  AST_BL_NO_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    blmode != BLM_RSVD); // R2
  AST_CL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat >= LAT_W'(5)) && (cas_lat <= LAT_W'(14))); // R9
  AST_WR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rec >= LAT_W'(5)) && (wr_rec <= LAT_W'(14)) && ((wr_rec <= LAT_W'(8)) || !wr_rec[0])); // R8
  AST_NO_MRS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mrs0_hit |=> ($stable(cas_lat) && $stable(wr_rec) && $stable(cfg_err))); // R1

endmodule

// File: rtl/colseq_order.sv
module colseq_order #(
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] start_low,
  input  logic [IDX_W-1:0] idx,
  input  logic             len8,
  input  logic             ilv,
  output logic [IDX_W-1:0] low_out
);

  localparam int HALF_W = IDX_W - 1;

  logic [IDX_W-1:0]  seq_full;
  logic [HALF_W-1:0] seq_half;
  logic [IDX_W-1:0]  seq_val;
  logic [IDX_W-1:0]  ilv_val;

  assign seq_full = start_low + idx;
  assign seq_half = start_low[HALF_W-1:0] + idx[HALF_W-1:0];

  // per-bit choice: top bit wraps only for 8-beat bursts
  for (genvar b = 0; b < IDX_W; b++) begin : g_bit
    if (b == IDX_W - 1) begin : g_top
      assign seq_val[b] = len8 ? seq_full[b] : start_low[b];
      assign ilv_val[b] = len8 ? (start_low[b] ^ idx[b]) : start_low[b];
    end else begin : g_low
      assign seq_val[b] = len8 ? seq_full[b] : seq_half[b];
      assign ilv_val[b] = start_low[b] ^ idx[b];
    end
  end

  assign low_out = ilv ? ilv_val : seq_val;

endmodule

// File: rtl/colseq_beat_ctrl.sv
module colseq_beat_ctrl
  import burst_colseq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_hit,
  input  logic             wr_hit,
  input  logic [COL_W-1:0] col_in,
  input  logic             otf_bit,
  input  blmode_e          blmode,
  input  logic             ilv,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_vld,
  output logic             beat_last,
  output logic [3:0]       burst_len,
  output logic             col_start
);

  localparam int IDX_W = 3;

  logic             active;
  logic [IDX_W-1:0] idx;
  logic [COL_W-1:0] start_q;
  logic             len8_q;
  logic             ilv_q;
  logic [COL_W-1:0] start_d;
  logic [IDX_W-1:0] low_col;
  logic [3:0]       run_cnt;

  assign col_start = (rd_hit | wr_hit) & ~active;
  assign start_d   = wr_hit ? {col_in[COL_W-1:2], 2'b00} : col_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      idx     <= '0;
      start_q <= '0;
      len8_q  <= 1'b1;
      ilv_q   <= 1'b0;
    end else if (col_start) begin
      active  <= 1'b1;
      idx     <= '0;
      start_q <= start_d;
      len8_q  <= len8_of(blmode, otf_bit);
      ilv_q   <= ilv;
    end else if (active) begin
      if (beat_last) active <= 1'b0;
      idx <= idx + 1'b1;
    end
  end

  colseq_order #(.IDX_W(IDX_W)) u_order (
    .start_low (start_q[IDX_W-1:0]),
    .idx       (idx),
    .len8      (len8_q),
    .ilv       (ilv_q),
    .low_out   (low_col)
  );

  assign beat_col  = {start_q[COL_W-1:IDX_W], low_col};
  assign beat_vld  = active;
  assign beat_last = active & (idx == (len8_q ? 3'd7 : 3'd3));
  assign burst_len = len8_q ? 4'd8 : 4'd4;

  // independent run-length counter for the checks below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else        run_cnt <= beat_vld ? run_cnt + 1'b1 : 4'd0;
  end

  AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_vld); // R11
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> (run_cnt + 4'd1 == burst_len)); // R11
  AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |=> !beat_vld); // R11
  AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && !beat_last) |=> (beat_col[COL_W-1:3] == $past(beat_col[COL_W-1:3]))); // R6
  AST_WRITE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (col_start && wr_hit) |=> (beat_col[1:0] == 2'b00)); // R7
  AST_BUSY_HOLDS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && !beat_last) |=> ($stable(burst_len) && beat_vld)); // R12
  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_len == 4'd4) || (burst_len == 4'd8)); // R3

endmodule

// File: rtl/burst_colseq.sv
module burst_colseq
  import burst_colseq_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ADDR_W = 16,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic              sel_n,
  input  logic              row_strobe_n,
  input  logic              col_strobe_n,
  input  logic              wr_en_n,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic [COL_W-1:0]  beat_col,
  output logic              beat_vld,
  output logic              beat_last,
  output logic [3:0]        burst_len,
  output logic [LAT_W-1:0]  cas_lat,
  output logic [LAT_W-1:0]  wr_rec,
  output logic              cfg_err
);

  localparam int OTF_BIT = 12;

  logic       mrs0_hit;
  logic       rd_hit;
  logic       wr_hit;
  logic       mrs_reject;
  logic       col_start;
  logic       ilv;
  blmode_e    blmode;
  mr_fields_t fld;

  assign fld.hi_zero = cmd_addr[15:13];
  assign fld.wr_code = cmd_addr[11:9];
  assign fld.cl_code = {cmd_addr[6:4], cmd_addr[2]};
  assign fld.ilv     = cmd_addr[3];
  assign fld.bl      = cmd_addr[1:0];

  colseq_cmd_dec #(.BANK_W(BANK_W)) u_dec (
    .cmd_vld      (cmd_vld),
    .sel_n        (sel_n),
    .row_strobe_n (row_strobe_n),
    .col_strobe_n (col_strobe_n),
    .wr_en_n      (wr_en_n),
    .bank_sel     (bank_sel),
    .mrs0_hit     (mrs0_hit),
    .rd_hit       (rd_hit),
    .wr_hit       (wr_hit)
  );

  colseq_modereg u_mr (
    .clk        (clk),
    .rst_n      (rst_n),
    .mrs0_hit   (mrs0_hit),
    .fld        (fld),
    .blmode     (blmode),
    .ilv        (ilv),
    .cas_lat    (cas_lat),
    .wr_rec     (wr_rec),
    .cfg_err    (cfg_err),
    .mrs_reject (mrs_reject)
  );

  colseq_beat_ctrl #(.COL_W(COL_W)) u_beat (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_hit    (rd_hit),
    .wr_hit    (wr_hit),
    .col_in    (cmd_addr[COL_W-1:0]),
    .otf_bit   (cmd_addr[OTF_BIT]),
    .blmode    (blmode),
    .ilv       (ilv),
    .beat_col  (beat_col),
    .beat_vld  (beat_vld),
    .beat_last (beat_last),
    .burst_len (burst_len),
    .col_start (col_start)
  );

  AST_MRS_NOT_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    !(mrs0_hit && (rd_hit || wr_hit))); // R1
  AST_REJECT_IS_MRS: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_reject |-> mrs0_hit); // R10
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    col_start |=> (beat_vld && !$past(beat_vld))); // R12

endmodule

// File: tb/burst_colseq_tb.sv
module burst_colseq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_vld = 1'b0;
  logic        sel_n = 1'b1;
  logic        row_strobe_n = 1'b1;
  logic        col_strobe_n = 1'b1;
  logic        wr_en_n = 1'b1;
  logic [2:0]  bank_sel = 3'd0;
  logic [15:0] cmd_addr = 16'd0;
  logic [9:0]  beat_col;
  logic        beat_vld;
  logic        beat_last;
  logic [3:0]  burst_len;
  logic [3:0]  cas_lat;
  logic [3:0]  wr_rec;
  logic        cfg_err;

  int checks = 0;
  int errors = 0;
  int exp_cl = 5;
  int exp_wr = 5;
  bit done = 0;

  always #5 clk = ~clk;

  burst_colseq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .sel_n(sel_n),
    .row_strobe_n(row_strobe_n), .col_strobe_n(col_strobe_n), .wr_en_n(wr_en_n),
    .bank_sel(bank_sel), .cmd_addr(cmd_addr), .beat_col(beat_col),
    .beat_vld(beat_vld), .beat_last(beat_last), .burst_len(burst_len),
    .cas_lat(cas_lat), .wr_rec(wr_rec), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic [15:0] mk_mr(input int bl, input bit il, input int clc, input int wrc);
    logic [15:0] a;
    a = 16'd0;
    a[1:0]  = 2'(bl);
    a[2]    = clc[0];
    a[3]    = il;
    a[6:4]  = 3'(clc >> 1);
    a[11:9] = 3'(wrc);
    return a;
  endfunction

  function automatic int exp_low(input int s, input int i, input int len, input bit il);
    if (il) return s ^ i;
    if (len == 8) return (s + i) % 8;
    return (s / 4) * 4 + ((s % 4) + i) % 4;
  endfunction

  task automatic idle_bus();
    cmd_vld = 1'b0; sel_n = 1'b1; row_strobe_n = 1'b1;
    col_strobe_n = 1'b1; wr_en_n = 1'b1; bank_sel = 3'd0;
  endtask

  task automatic raw_cmd(input bit s, input bit r, input bit c, input bit w,
                         input int bank, input [15:0] a);
    @(negedge clk);
    cmd_vld = 1'b1; sel_n = s; row_strobe_n = r; col_strobe_n = c; wr_en_n = w;
    bank_sel = 3'(bank); cmd_addr = a;
    @(negedge clk);
    idle_bus();
  endtask

  task automatic mrs(input int bank, input [15:0] a);
    raw_cmd(1'b0, 1'b0, 1'b0, 1'b0, bank, a);
  endtask

  // issues a column command, checks every beat; inj_at >= 0 fires a second read there
  task automatic run_burst(input bit wr, input int col, input bit a12, input int len,
                           input bit il, input string req, input int inj_at);
    int s;
    int base;
    s = wr ? (col & 4) : (col & 7);
    base = col & 10'h3F8;
    @(negedge clk);
    cmd_vld = 1'b1; sel_n = 1'b0; row_strobe_n = 1'b1; col_strobe_n = 1'b0;
    wr_en_n = !wr; bank_sel = 3'd2;
    cmd_addr = 16'(col) | (a12 ? 16'h1000 : 16'h0000);
    @(negedge clk);
    idle_bus();
    check(len == 8 ? "R2" : "R3", "burst_len", int'(burst_len), len);
    for (int i = 0; i < len; i++) begin
      check("R11", "beat_vld", int'(beat_vld), 1);
      check("R11", "beat_last", int'(beat_last), (i == len - 1) ? 1 : 0);
      check("R6", "upper col", int'(beat_col) & 10'h3F8, base);
      check(req, "low col", int'(beat_col) & 7, exp_low(s, i, len, il));
      if (i == inj_at) begin
        cmd_vld = 1'b1; sel_n = 1'b0; row_strobe_n = 1'b1; col_strobe_n = 1'b0;
        wr_en_n = 1'b1; cmd_addr = 16'h03F3;
      end
      @(negedge clk);
      if (i == inj_at) idle_bus();
    end
    check(inj_at >= 0 ? "R12" : "R11", "beat_vld after burst", int'(beat_vld), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    check("R13", "beat_vld", int'(beat_vld), 0);
    check("R13", "beat_last", int'(beat_last), 0);
    check("R13", "burst_len", int'(burst_len), 8);
    check("R13", "cas_lat", int'(cas_lat), 5);
    check("R13", "wr_rec", int'(wr_rec), 5);
    check("R13", "cfg_err", int'(cfg_err), 0);
    run_burst(1'b0, 10'h2A5, 1'b0, 8, 1'b0, "R13", -1);

    // R9 latency code sweep
    for (int c = 0; c < 16; c++) begin
      bit ok;
      ok = ((c % 2 == 0) && c >= 2) || ((c % 2 == 1) && c <= 5);
      mrs(0, mk_mr(0, 1'b0, c, 1));
      if (ok) begin
        exp_cl = (c % 2 == 1) ? 12 + c / 2 : 4 + c / 2;
        exp_wr = 5;
      end
      check("R9", "cas_lat", int'(cas_lat), exp_cl);
      check("R10", "cfg_err", int'(cfg_err), ok ? 0 : 1);
    end

    // R8 recovery code sweep
    for (int c = 0; c < 8; c++) begin
      mrs(0, mk_mr(0, 1'b0, 2, c));
      if (c != 0) begin
        exp_wr = (c < 5) ? c + 4 : 2 * c;
        exp_cl = 5;
      end
      check("R8", "wr_rec", int'(wr_rec), exp_wr);
      check("R10", "cfg_err", int'(cfg_err), (c == 0) ? 1 : 0);
    end

    // R1: good setting, then decoys that must be ignored
    mrs(0, mk_mr(2, 1'b0, 4, 3));
    check("R1", "cas_lat", int'(cas_lat), 6);
    check("R1", "wr_rec", int'(wr_rec), 7);
    mrs(1, mk_mr(0, 1'b1, 12, 6));
    check("R1", "cas_lat other bank", int'(cas_lat), 6);
    check("R1", "wr_rec other bank", int'(wr_rec), 7);
    raw_cmd(1'b1, 1'b0, 1'b0, 1'b0, 0, mk_mr(0, 1'b1, 12, 6));
    check("R1", "cas_lat deselected", int'(cas_lat), 6);
    check("R1", "cfg_err deselected", int'(cfg_err), 0);
    run_burst(1'b0, 10'h10E, 1'b1, 4, 1'b0, "R1", -1);

    // R10: reserved length code and nonzero top bits refused
    mrs(0, mk_mr(3, 1'b1, 12, 6));
    check("R10", "cfg_err rsvd bl", int'(cfg_err), 1);
    check("R10", "cas_lat rsvd bl", int'(cas_lat), 6);
    run_burst(1'b0, 10'h10E, 1'b1, 4, 1'b0, "R10", -1);
    mrs(0, mk_mr(0, 1'b1, 12, 6) | 16'h4000);
    check("R10", "cfg_err hi bits", int'(cfg_err), 1);
    check("R10", "wr_rec hi bits", int'(wr_rec), 7);
    run_burst(1'b0, 10'h10E, 1'b1, 4, 1'b0, "R10", -1);

    // R2..R7 full order sweep
    for (int il = 0; il < 2; il++) begin
      for (int m = 0; m < 4; m++) begin
        int bl;
        int len;
        bit a12;
        bl  = (m == 0) ? 0 : (m == 3) ? 2 : 1;
        a12 = (m == 2);
        len = (m == 0 || m == 2) ? 8 : 4;
        mrs(0, mk_mr(bl, il[0], 2, 1));
        check("R10", "cfg_err valid", int'(cfg_err), 0);
        for (int w = 0; w < 2; w++) begin
          for (int s = 0; s < 8; s++) begin
            int col;
            string req;
            col = (((s * 37 + m * 11 + w * 5) & 127) << 3) | s;
            req = (w == 1) ? "R7" : (il == 1) ? "R5" : "R4";
            run_burst(w[0], col, a12, len, il[0], req, -1);
          end
        end
      end
    end

    // R12: commands during a running burst are dropped
    mrs(0, mk_mr(0, 1'b0, 2, 1));
    run_burst(1'b0, 10'h1D5, 1'b0, 8, 1'b0, "R12", 2);
    run_burst(1'b0, 10'h1D5, 1'b0, 8, 1'b0, "R12", 7);
    mrs(0, mk_mr(1, 1'b1, 2, 1));
    run_burst(1'b0, 10'h0C6, 1'b0, 4, 1'b1, "R12", 3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule